// File: doc/BRIEF.md
# Predicate Row Selection Filter

The block sits in a table-scan datapath and keeps or discards whole table rows. A row arrives as a stream of 32-bit column words, one per accepted cycle, and column 0 comes first. Sixteen predicate units each compare one chosen column against a signed 32-bit constant. Their results are combined as an OR of four AND groups. The row is held in a 32-word buffer while it arrives. When the row ends, it is either sent downstream word for word or discarded in the same cycle.

Predicates are loaded through a simple write port, one predicate per write, and should be written between rows. Predicate `p` belongs to AND group `p/4`. Enabling or disabling predicates sets which comparisons each group holds. Two counters report how many rows have ended and how many of them passed. A start pulse clears both counters.

Top module: `row_filter`

## Requirements
- R1: While reset is held and on the first cycle after it, `in_ready_o` is 1, `out_valid_o` is 0, and both counters read 0.
- R2: A predicate compares the word at zero-based position `col` of the row against its constant as signed 32-bit values. The operator codes are 0 equal, 1 not equal, 2 less than, 3 less or equal, 4 greater than and 5 greater or equal. The word is always the left operand.
- R3: Group g is made of predicates 4g to 4g+3 and is true when all of its enabled predicates are true. A disabled predicate does not affect its group.
- R4: A group with no enabled predicate is false. When no predicate is enabled at all, every row is dropped.
- R5: A row passes when at least one group is true.
- R6: An enabled predicate whose column index is not less than the row length evaluates false.
- R7: A passing row is sent out with all its words unchanged and in arrival order. `out_last_o` is 1 only on its final word, and `out_valid_o` rises in the cycle after the row's final input word is accepted.
- R8: A failing row produces no output, and `in_ready_o` stays 1 so the next row can start in the next cycle.
- R9: The 32nd word of a row ends the row even when `in_last_i` is 0.
- R10: While a passing row is being sent out, `in_ready_o` is 0. Under back-pressure, `out_data_o` and `out_last_o` hold their values.
- R11: On the cycle after a row ends, `rows_seen_o` has gone up by 1 and `rows_passed_o` has gone up by 1 if the row passed. A `start_i` pulse clears both counters, and it takes priority over a row ending in the same cycle.
- R12: Operator codes 6 and 7 never evaluate true.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Clears the row counters |
| cfg_we_i | input | 1 | Writes one predicate |
| cfg_idx_i | input | 4 | Predicate number to write |
| cfg_en_i | input | 1 | Predicate enable |
| cfg_col_i | input | 5 | Column position tested |
| cfg_op_i | input | 3 | Operator code |
| cfg_const_i | input | 32 | Signed constant |
| in_valid_i | input | 1 | Input word valid |
| in_ready_o | output | 1 | Input word accepted |
| in_data_i | input | 32 | Column word |
| in_last_i | input | 1 | Final word of the row |
| out_valid_o | output | 1 | Output word valid |
| out_ready_i | input | 1 | Downstream accepts |
| out_data_o | output | 32 | Forwarded column word |
| out_last_o | output | 1 | Final word of a forwarded row |
| rows_seen_o | output | 32 | Rows ended since start |
| rows_passed_o | output | 32 | Rows passed since start |

## Verification
The decision for a row is due in the cycle after its final word is accepted. In that cycle `out_valid_o` equals the expected pass bit, both counters show the new row, and `in_ready_o` is 0 exactly when the row passed. The bench drives inputs on the falling edge, waits for the rising edge that accepts the final word, and samples on the next falling edge. Each output word is checked on the falling edge before the rising edge that consumes it. `out_ready_i` is randomized, so words are also checked while they are held under stall. After the final output word is consumed, the bench checks on the next falling edge that `in_ready_o` has come back.

// File: rtl/row_filter_pkg.sv
package row_filter_pkg;
  localparam int DATA_W     = 32;
  localparam int MAX_COLS   = 32;
  localparam int NUM_PRED   = 16;
  localparam int GROUP_SIZE = 4;
  localparam int CNT_W      = 32;

  typedef enum logic [2:0] {
    OP_EQ = 3'd0,
    OP_NE = 3'd1,
    OP_LT = 3'd2,
    OP_LE = 3'd3,
    OP_GT = 3'd4,
    OP_GE = 3'd5
  } cmp_op_e;

  typedef enum logic {
    ST_FILL  = 1'b0,
    ST_DRAIN = 1'b1
  } flt_state_e;
endpackage

// File: rtl/rf_pred_unit.sv
module rf_pred_unit
  import row_filter_pkg::*;
#(
  parameter int DW = 32,
  parameter int CW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cfg_we_i,
  input  logic          cfg_en_i,
  input  logic [CW-1:0] cfg_col_i,
  input  logic [2:0]    cfg_op_i,
  input  logic [DW-1:0] cfg_const_i,
  input  logic          word_fire_i,
  input  logic [CW-1:0] word_idx_i,
  input  logic [DW-1:0] word_data_i,
  input  logic          row_end_i,
  output logic          en_o,
  output logic          res_o
);
  logic          en_q;
  logic [CW-1:0] col_q;
  logic [2:0]    op_q;
  logic [DW-1:0] k_q;
  logic          hit_q;
  logic          cmp_true;
  logic          match;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      col_q <= '0;
      op_q  <= '0;
      k_q   <= '0;
    end else if (cfg_we_i) begin
      en_q  <= cfg_en_i;
      col_q <= cfg_col_i;
      op_q  <= cfg_op_i;
      k_q   <= cfg_const_i;
    end
  end

  always_comb begin
    unique case (op_q)
      OP_EQ:   cmp_true = word_data_i == k_q;
      OP_NE:   cmp_true = word_data_i != k_q;
      OP_LT:   cmp_true = $signed(word_data_i) <  $signed(k_q);
      OP_LE:   cmp_true = $signed(word_data_i) <= $signed(k_q);
      OP_GT:   cmp_true = $signed(word_data_i) >  $signed(k_q);
      OP_GE:   cmp_true = $signed(word_data_i) >= $signed(k_q);
      default: cmp_true = 1'b0;
    endcase
  end

  assign match = word_fire_i && (col_q == word_idx_i) && cmp_true;
  assign res_o = hit_q | match;
  assign en_o  = en_q;

  // hit stays low when the column never shows up in the row
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        hit_q <= 1'b0;
    else if (row_end_i) hit_q <= 1'b0;
    else if (match)     hit_q <= 1'b1;
  end
endmodule

// File: rtl/rf_sop_tree.sv
module rf_sop_tree #(
  parameter int NG = 4,
  parameter int GS = 4
) (
  input  logic [NG*GS-1:0] en_i,
  input  logic [NG*GS-1:0] res_i,
  output logic             pass_o
);
  logic [NG-1:0] term;

  for (genvar g = 0; g < NG; g++) begin : g_grp
    logic [GS-1:0] en_g;
    logic [GS-1:0] res_g;
    assign en_g    = en_i[g*GS +: GS];
    assign res_g   = res_i[g*GS +: GS];
    assign term[g] = (|en_g) && (&(res_g | ~en_g));
  end

  assign pass_o = |term;
endmodule

// File: rtl/rf_row_buffer.sv
module rf_row_buffer #(
  parameter int DW    = 32,
  parameter int DEPTH = 32,
  parameter int AW    = 5
) (
  input  logic          clk_i,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_idx_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic [AW-1:0] rd_idx_i,
  output logic [DW-1:0] rd_data_o
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[wr_idx_i] <= wr_data_i;
  end

  assign rd_data_o = mem_q[rd_idx_i];
endmodule

// File: rtl/row_filter.sv
module row_filter
  import row_filter_pkg::*;
#(
  parameter int DW    = row_filter_pkg::DATA_W,
  parameter int NCOL  = row_filter_pkg::MAX_COLS,
  parameter int NPRED = row_filter_pkg::NUM_PRED,
  parameter int GSIZE = row_filter_pkg::GROUP_SIZE,
  parameter int CNTW  = row_filter_pkg::CNT_W,
  localparam int CW   = $clog2(NCOL),
  localparam int PW   = $clog2(NPRED),
  localparam int NG   = NPRED / GSIZE
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic            cfg_we_i,
  input  logic [PW-1:0]   cfg_idx_i,
  input  logic            cfg_en_i,
  input  logic [CW-1:0]   cfg_col_i,
  input  logic [2:0]      cfg_op_i,
  input  logic [DW-1:0]   cfg_const_i,
  input  logic            in_valid_i,
  output logic            in_ready_o,
  input  logic [DW-1:0]   in_data_i,
  input  logic            in_last_i,
  output logic            out_valid_o,
  input  logic            out_ready_i,
  output logic [DW-1:0]   out_data_o,
  output logic            out_last_o,
  output logic [CNTW-1:0] rows_seen_o,
  output logic [CNTW-1:0] rows_passed_o
);
  flt_state_e     state_q;
  logic [CW-1:0]  wr_idx_q;
  logic [CW-1:0]  rd_idx_q;
  logic [CW-1:0]  end_idx_q;
  logic           in_fire;
  logic           out_fire;
  logic           row_end;
  logic           row_pass;
  logic [NPRED-1:0] p_en;
  logic [NPRED-1:0] p_res;

  assign in_ready_o  = (state_q == ST_FILL);
  assign in_fire     = in_valid_i && in_ready_o;
  assign row_end     = in_fire && (in_last_i || (wr_idx_q == CW'(NCOL-1)));
  assign out_valid_o = (state_q == ST_DRAIN);
  assign out_fire    = out_valid_o && out_ready_i;
  assign out_last_o  = out_valid_o && (rd_idx_q == end_idx_q);

  for (genvar p = 0; p < NPRED; p++) begin : g_pred
    rf_pred_unit #(.DW(DW), .CW(CW)) u_pred (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .cfg_we_i    (cfg_we_i && (cfg_idx_i == PW'(p))),
      .cfg_en_i    (cfg_en_i),
      .cfg_col_i   (cfg_col_i),
      .cfg_op_i    (cfg_op_i),
      .cfg_const_i (cfg_const_i),
      .word_fire_i (in_fire),
      .word_idx_i  (wr_idx_q),
      .word_data_i (in_data_i),
      .row_end_i   (row_end),
      .en_o        (p_en[p]),
      .res_o       (p_res[p])
    );
  end

  rf_sop_tree #(.NG(NG), .GS(GSIZE)) u_tree (
    .en_i   (p_en),
    .res_i  (p_res),
    .pass_o (row_pass)
  );

  rf_row_buffer #(.DW(DW), .DEPTH(NCOL), .AW(CW)) u_buf (
    .clk_i     (clk_i),
    .wr_en_i   (in_fire),
    .wr_idx_i  (wr_idx_q),
    .wr_data_i (in_data_i),
    .rd_idx_i  (rd_idx_q),
    .rd_data_o (out_data_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_FILL;
      wr_idx_q  <= '0;
      rd_idx_q  <= '0;
      end_idx_q <= '0;
    end else begin
      unique case (state_q)
        ST_FILL: begin
          if (row_end) begin
            wr_idx_q  <= '0;
            rd_idx_q  <= '0;
            end_idx_q <= wr_idx_q;
            // failing row: buffer is simply overwritten by the next row
            if (row_pass) state_q <= ST_DRAIN;
          end else if (in_fire) begin
            wr_idx_q <= wr_idx_q + 1'b1;
          end
        end
        ST_DRAIN: begin
          if (out_fire) begin
            if (out_last_o) state_q  <= ST_FILL;
            else            rd_idx_q <= rd_idx_q + 1'b1;
          end
        end
        default: state_q <= ST_FILL;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rows_seen_o   <= '0;
      rows_passed_o <= '0;
    end else if (start_i) begin
      rows_seen_o   <= '0;
      rows_passed_o <= '0;
    end else if (row_end) begin
      rows_seen_o <= rows_seen_o + 1'b1;
      if (row_pass) rows_passed_o <= rows_passed_o + 1'b1;
    end
  end
endmodule

// File: rtl/row_filter_chk.sv
module row_filter_chk #(
  parameter int DW   = 32,
  parameter int CNTW = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            start_i,
  input logic            in_valid_i,
  input logic            in_ready_o,
  input logic            out_valid_o,
  input logic            out_ready_i,
  input logic [DW-1:0]   out_data_o,
  input logic            out_last_o,
  input logic [CNTW-1:0] rows_seen_o,
  input logic [CNTW-1:0] rows_passed_o
);
  // R10
  drain_blocks_input_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> !in_ready_o);

  // R10
  hold_under_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_data_o) && $stable(out_last_o)));

  // R7
  last_returns_fill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_ready_i && out_last_o) |=> (!out_valid_o && in_ready_o));

  // R11
  start_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (rows_seen_o == '0 && rows_passed_o == '0));

  // R11
  passed_bounded_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rows_passed_o <= rows_seen_o);

  // R11
  seen_needs_input_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_i && !(in_valid_i && in_ready_o)) |=> $stable(rows_seen_o));
endmodule

bind row_filter row_filter_chk #(.DW(DW), .CNTW(CNTW)) u_chk (.*);

// File: tb/row_filter_test.sv
module row_filter_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [3:0]  cfg_idx_i = '0;
  logic        cfg_en_i = 1'b0;
  logic [4:0]  cfg_col_i = '0;
  logic [2:0]  cfg_op_i = '0;
  logic [31:0] cfg_const_i = '0;
  logic        in_valid_i = 1'b0;
  logic        in_ready_o;
  logic [31:0] in_data_i = '0;
  logic        in_last_i = 1'b0;
  logic        out_valid_o;
  logic        out_ready_i = 1'b0;
  logic [31:0] out_data_o;
  logic        out_last_o;
  logic [31:0] rows_seen_o;
  logic [31:0] rows_passed_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;
  int exp_seen = 0;
  int exp_pass = 0;

  bit          m_en  [16];
  int          m_col [16];
  int          m_op  [16];
  int signed   m_k   [16];
  int signed   row_w [32];

  always #2 clk_i = ~clk_i;

  row_filter uut (.*);

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit cmp(input int op, input int signed a, input int signed k);
    case (op)
      0: return a == k;
      1: return a != k;
      2: return a < k;
      3: return a <= k;
      4: return a > k;
      5: return a >= k;
      default: return 1'b0;
    endcase
  endfunction

  function automatic bit model_pass(input int n);
    bit res [16];
    for (int p = 0; p < 16; p++)
      res[p] = (m_col[p] < n) && cmp(m_op[p], row_w[m_col[p]], m_k[p]);
    for (int g = 0; g < 4; g++) begin
      bit any_en = 0;
      bit all_ok = 1;
      for (int j = 0; j < 4; j++) begin
        int p = g * 4 + j;
        if (m_en[p]) begin
          any_en = 1;
          if (!res[p]) all_ok = 0;
        end
      end
      if (any_en && all_ok) return 1'b1;
    end
    return 1'b0;
  endfunction

  task automatic cfg_write(input int idx, input bit en, input int col, input int op, input int signed k);
    @(negedge clk_i);
    cfg_we_i = 1; cfg_idx_i = 4'(idx); cfg_en_i = en;
    cfg_col_i = 5'(col); cfg_op_i = 3'(op); cfg_const_i = k;
    m_en[idx] = en; m_col[idx] = col; m_op[idx] = op; m_k[idx] = k;
    @(negedge clk_i);
    cfg_we_i = 0;
  endtask

  task automatic clear_cfg();
    for (int p = 0; p < 16; p++) cfg_write(p, 0, 0, 0, 0);
  endtask

  // sends row_w[0..n-1]; at return we sit on the falling edge after the final accept
  task automatic run_row(input int n, input bit use_last, input string tag);
    bit exp;
    int i;
    exp = model_pass(n);
    @(negedge clk_i);
    for (int w = 0; w < n; w++) begin
      in_valid_i = 1; in_data_i = row_w[w];
      in_last_i = use_last && (w == n - 1);
      while (!in_ready_o) @(negedge clk_i);
      @(posedge clk_i);
      @(negedge clk_i);
    end
    in_valid_i = 0; in_last_i = 0;
    exp_seen++;
    if (exp) exp_pass++;
    chk(out_valid_o == exp, {tag, " R5 decision"}, out_valid_o, exp);
    chk(in_ready_o == !exp, {tag, " R8 ready after decision"}, in_ready_o, !exp);
    chk(rows_seen_o == 32'(exp_seen), {tag, " R11 seen"}, rows_seen_o, exp_seen);
    chk(rows_passed_o == 32'(exp_pass), {tag, " R11 passed"}, rows_passed_o, exp_pass);
    if (exp && out_valid_o) begin
      i = 0;
      while (i < n) begin
        out_ready_i = ($urandom % 4) != 0;
        #0;
        chk(out_valid_o, {tag, " R7 valid"}, out_valid_o, 1);
        chk(out_data_o == row_w[i], {tag, " R7 data"}, out_data_o, row_w[i]);
        chk(out_last_o == (i == n - 1), {tag, " R7 last"}, out_last_o, i == n - 1);
        chk(!in_ready_o, {tag, " R10 stalled input"}, in_ready_o, 0);
        @(posedge clk_i);
        if (out_ready_i) i++;
        @(negedge clk_i);
      end
      out_ready_i = 0;
      chk(!out_valid_o && in_ready_o, {tag, " R7 back to fill"}, out_valid_o, 0);
    end
  endtask

  initial begin
    int seed_v;
    seed_v = $urandom(32'h5eed_2024);
    for (int p = 0; p < 16; p++) begin m_en[p] = 0; m_col[p] = 0; m_op[p] = 0; m_k[p] = 0; end
    #1;
    chk(in_ready_o && !out_valid_o, "R1 ready in reset", in_ready_o, 1);
    chk(rows_seen_o == 0 && rows_passed_o == 0, "R1 counters in reset", rows_seen_o, 0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    chk(in_ready_o && !out_valid_o, "R1 ready after reset", out_valid_o, 0);

    // R4: nothing enabled drops everything
    for (int w = 0; w < 4; w++) row_w[w] = w;
    run_row(4, 1, "R4 none enabled");

    // R2 signed less-than on column 2
    cfg_write(0, 1, 2, 2, 40);
    row_w[0] = 100; row_w[1] = 100; row_w[2] = 39;
    run_row(3, 1, "R2 lt 39");
    row_w[2] = 40;
    run_row(3, 1, "R2 lt 40");
    row_w[2] = -5;
    run_row(3, 1, "R2 lt negative");

    // R3 AND with a second predicate; R3 disabled predicate neutral
    cfg_write(1, 1, 0, 5, 10);
    row_w[0] = 10; row_w[2] = 0;
    run_row(3, 1, "R3 both true");
    row_w[0] = 9;
    run_row(3, 1, "R3 one false");
    cfg_write(1, 0, 0, 5, 10);
    run_row(3, 1, "R3 disabled neutral");

    // R5 OR through group 2
    cfg_write(8, 1, 3, 0, 100);
    row_w[2] = 50; row_w[3] = 100;
    run_row(4, 1, "R5 second group");
    row_w[3] = 101;
    run_row(4, 1, "R5 no group");

    // R6 column beyond row length
    clear_cfg();
    cfg_write(4, 1, 5, 1, 7);
    for (int w = 0; w < 3; w++) row_w[w] = 1;
    run_row(3, 1, "R6 short row");
    for (int w = 0; w < 6; w++) row_w[w] = 1;
    run_row(6, 1, "R6 long enough");

    // R12 reserved codes
    cfg_write(4, 1, 0, 6, 0);
    cfg_write(5, 1, 0, 7, 0);
    cfg_write(6, 0, 0, 0, 0);
    row_w[0] = 0;
    run_row(1, 1, "R12 codes 6 and 7");
    cfg_write(4, 0, 0, 0, 0);
    run_row(1, 1, "R12 code 7 alone");

    // R9 32 words, no last flag
    clear_cfg();
    cfg_write(15, 1, 31, 4, 0);
    for (int w = 0; w < 32; w++) row_w[w] = 1000 + w;
    run_row(32, 0, "R9 implicit end");
    row_w[0] = 7;
    run_row(1, 1, "R9 next row single");

    // R11 start clears
    @(negedge clk_i); start_i = 1;
    @(negedge clk_i); start_i = 0;
    exp_seen = 0; exp_pass = 0;
    chk(rows_seen_o == 0 && rows_passed_o == 0, "R11 start clear", rows_seen_o, 0);

    // random
    for (int r = 0; r < 300; r++) begin
      int n;
      if (r % 25 == 0) begin
        clear_cfg();
        for (int k = 0; k < 5; k++)
          cfg_write($urandom % 16, 1, $urandom % 6, $urandom % 8, int'($urandom % 12) - 3);
      end
      n = 1 + $urandom % 8;
      for (int w = 0; w < n; w++) row_w[w] = int'($urandom % 12) - 3;
      run_row(n, 1, "R2 R3 R5 random");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule